// File: doc/BRIEF.md
# Register and IO Execute Unit

This block runs the last step of an opcode-7 instruction in a small 16-bit accumulator machine. A sequencer hands it a start strobe with a select code and the indirect bit. With the indirect bit low the code picks a register operation on the accumulator and the extend bit. With it high the code is one-hot and picks an input/output operation. Those operations use an 8-bit input holding register, an 8-bit output register, an input-ready flag, an output-ready flag and the interrupt enable flag. The unit does not move the program counter or stop the fetch itself. It reports a skip pulse and a sticky halt back to the sequencer and ends every instruction with a one-cycle done pulse.

The unit owns the accumulator, the extend bit and the three flags. The memory-reference side of the machine writes the accumulator and extend bit through a shared write port. Peripheral strobes fill the input register and mark the output as consumed.

The control is a three-state machine. ST_IDLE waits for a start and takes the code and indirect bit when one arrives (transition IDLE->EXEC). ST_EXEC applies the selected operation in one cycle. It returns to ST_IDLE (EXEC->IDLE), or it goes to ST_HALTED when the operation was a halt (EXEC->HALTED). ST_HALTED ignores every later start until reset.

Top module: `rio_exec_unit`

## Requirements
- R1: After reset the accumulator, extend bit, all three flags, the output register, skip, halt and done are all 0.
- R2: A start accepted in ST_IDLE gives exactly one done pulse two clock edges later. Results are visible in the same cycle as that pulse, and a start seen while in ST_EXEC is ignored.
- R3: Register code 0 raises halt together with done. Halt stays high until reset, and later starts produce no done and leave the accumulator unchanged.
- R4: Register codes 1 to 4 pulse skip with done when their condition holds. The conditions are: 1 extend bit is 0, 2 accumulator is 0, 3 accumulator bit 15 is 1, 4 accumulator bit 15 is 0.
- R5: Register code 5 adds one to the accumulator modulo 2^16. Code 9 inverts every accumulator bit, and code 11 clears the accumulator.
- R6: Register code 6 rotates the 17-bit {extend, accumulator} left: the extend bit enters bit 0 and bit 15 goes to the extend bit. Code 7 rotates right: the extend bit enters bit 15 and bit 0 goes to the extend bit.
- R7: Register code 8 inverts the extend bit, and code 10 clears it.
- R8: IO code 1 (bit 0) clears the interrupt enable flag, and IO code 2 (bit 1) sets it.
- R9: IO code 4 (bit 2) skips when the output-ready flag is 1. IO code 8 (bit 3) skips when the input-ready flag is 1.
- R10: IO code 16 (bit 4) copies accumulator bits 7:0 to the output register and clears the output-ready flag. IO code 32 (bit 5) loads the input register, zero-extended, into the accumulator and clears the input-ready flag.
- R11: An input strobe loads the input register and sets input-ready on the next edge. An output-consumed strobe sets output-ready. A peripheral set wins over a same-cycle clear by an IO operation.
- R12: Register codes 12 to 63, and IO codes that are zero or not one-hot, change nothing and raise no skip, but done still pulses.
- R13: The external write port updates the accumulator or extend bit on the next edge. When an executing operation writes the same register in that cycle, the operation's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an opcode-7 instruction |
| sel | input | 6 | Operation select code |
| ind | input | 1 | Group select: 0 register, 1 IO |
| ac_wr | input | 1 | External accumulator write enable |
| ac_wdata | input | 16 | External accumulator write value |
| e_wr | input | 1 | External extend-bit write enable |
| e_wdata | input | 1 | External extend-bit write value |
| in_strobe | input | 1 | Peripheral has new input data |
| in_data | input | 8 | Peripheral input byte |
| out_ack | input | 1 | Peripheral has consumed the output byte |
| ac | output | 16 | Accumulator |
| e | output | 1 | Extend bit |
| ien | output | 1 | Interrupt enable flag |
| fgi | output | 1 | Input-ready flag |
| fgo | output | 1 | Output-ready flag |
| out_data | output | 8 | Output register |
| skip | output | 1 | Request one extra program counter increment |
| halt | output | 1 | Sticky stop indication |
| done | output | 1 | Instruction complete pulse |

## Verification
A peripheral strobe and an IO operation that clears the same flag can meet in the ST_EXEC cycle. The bench provokes this by raising the input strobe, with a new byte, in the execute cycle of a load-input operation. It does the same with the output-consumed strobe during a store-output operation. The scoreboard then expects the accumulator to hold the old input byte, and expects the flag to read 1, because the peripheral set wins. A second collision puts the external accumulator write in the same execute cycle as an increment. There the increment's result is expected. With a skip-only operation the written value is expected instead.

// File: rtl/rio_pkg.sv
package rio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_HALTED = 2'd2
    } rio_state_e;

    // register-group select values
    localparam int OP_HLT = 0;
    localparam int OP_SZE = 1;
    localparam int OP_SZA = 2;
    localparam int OP_SNA = 3;
    localparam int OP_SPA = 4;
    localparam int OP_INC = 5;
    localparam int OP_ROL = 6;
    localparam int OP_ROR = 7;
    localparam int OP_CME = 8;
    localparam int OP_CMA = 9;
    localparam int OP_CLE = 10;
    localparam int OP_CLA = 11;

    // io-group one-hot bit positions
    localparam int IO_IEN_OFF = 0;
    localparam int IO_IEN_ON  = 1;
    localparam int IO_SK_OUT  = 2;
    localparam int IO_SK_IN   = 3;
    localparam int IO_PUT     = 4;
    localparam int IO_GET     = 5;

    // flag vector slots
    localparam int FL_IEN = 0;
    localparam int FL_IN  = 1;
    localparam int FL_OUT = 2;
    localparam int NFLAG  = 3;

endpackage

// File: rtl/rio_reg_alu.sv
module rio_reg_alu
    import rio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 6
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] ac,
    input  logic              e,
    output logic [DATA_W-1:0] ac_n,
    output logic              ac_we,
    output logic              e_n,
    output logic              e_we,
    output logic              skip,
    output logic              halt
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        ac_n  = ac;
        e_n   = e;
        ac_we = 1'b0;
        e_we  = 1'b0;
        skip  = 1'b0;
        halt  = 1'b0;
        case (sel)
            SEL_W'(OP_HLT): halt = 1'b1;
            SEL_W'(OP_SZE): skip = ~e;
            SEL_W'(OP_SZA): skip = (ac == '0);
            SEL_W'(OP_SNA): skip = ac[MSB];
            SEL_W'(OP_SPA): skip = ~ac[MSB];
            SEL_W'(OP_INC): begin
                ac_n  = ac + DATA_W'(1);
                ac_we = 1'b1;
            end
            SEL_W'(OP_ROL): begin
                ac_n  = {ac[MSB-1:0], e};
                e_n   = ac[MSB];
                ac_we = 1'b1;
                e_we  = 1'b1;
            end
            SEL_W'(OP_ROR): begin
                ac_n  = {e, ac[MSB:1]};
                e_n   = ac[0];
                ac_we = 1'b1;
                e_we  = 1'b1;
            end
            SEL_W'(OP_CME): begin
                e_n  = ~e;
                e_we = 1'b1;
            end
            SEL_W'(OP_CMA): begin
                ac_n  = ~ac;
                ac_we = 1'b1;
            end
            SEL_W'(OP_CLE): begin
                e_n  = 1'b0;
                e_we = 1'b1;
            end
            SEL_W'(OP_CLA): begin
                ac_n  = '0;
                ac_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rio_io_ops.sv
module rio_io_ops
    import rio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IO_W   = 8,
    parameter int SEL_W  = 6
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [IO_W-1:0]   ac_lo,
    input  logic [IO_W-1:0]   in_reg,
    input  logic              fgi,
    input  logic              fgo,
    output logic [DATA_W-1:0] ac_n,
    output logic              ac_we,
    output logic [IO_W-1:0]   out_n,
    output logic              out_we,
    output logic              skip,
    output logic [NFLAG-1:0]  fl_set,
    output logic [NFLAG-1:0]  fl_clr
);
    localparam int PAD_W = DATA_W - IO_W;

    logic one_hot;
    assign one_hot = (sel != '0) && ((sel & (sel - SEL_W'(1))) == '0);

    always_comb begin
        ac_n   = {{PAD_W{1'b0}}, in_reg};
        ac_we  = 1'b0;
        out_n  = ac_lo;
        out_we = 1'b0;
        skip   = 1'b0;
        fl_set = '0;
        fl_clr = '0;
        if (one_hot) begin
            if (sel[IO_IEN_OFF]) fl_clr[FL_IEN] = 1'b1;
            if (sel[IO_IEN_ON])  fl_set[FL_IEN] = 1'b1;
            if (sel[IO_SK_OUT])  skip = fgo;
            if (sel[IO_SK_IN])   skip = fgi;
            if (sel[IO_PUT]) begin
                out_we         = 1'b1;
                fl_clr[FL_OUT] = 1'b1;
            end
            if (sel[IO_GET]) begin
                ac_we         = 1'b1;
                fl_clr[FL_IN] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rio_flags.sv
module rio_flags
    import rio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    output logic [NFLAG-1:0] q
);
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[k] <= 1'b0;
            else if (set_v[k]) q[k] <= 1'b1;
            else if (clr_v[k]) q[k] <= 1'b0;
        end
    end

endmodule

// File: rtl/rio_exec_unit.sv
module rio_exec_unit
    import rio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IO_W   = 8,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel,
    input  logic              ind,
    input  logic              ac_wr,
    input  logic [DATA_W-1:0] ac_wdata,
    input  logic              e_wr,
    input  logic              e_wdata,
    input  logic              in_strobe,
    input  logic [IO_W-1:0]   in_data,
    input  logic              out_ack,
    output logic [DATA_W-1:0] ac,
    output logic              e,
    output logic              ien,
    output logic              fgi,
    output logic              fgo,
    output logic [IO_W-1:0]   out_data,
    output logic              skip,
    output logic              halt,
    output logic              done
);
    rio_state_e        state_q, state_d;
    logic [SEL_W-1:0]  sel_q;
    logic              ind_q;
    logic [DATA_W-1:0] ac_q;
    logic              e_q;
    logic [IO_W-1:0]   in_q, out_q;
    logic              skip_q, done_q, halt_q;
    logic [NFLAG-1:0]  flags, fl_set, fl_clr;

    logic              take, exec;
    logic [DATA_W-1:0] r_ac_n, i_ac_n;
    logic              r_ac_we, r_e_n, r_e_we, r_skip, r_halt;
    logic              i_ac_we, i_out_we, i_skip;
    logic [IO_W-1:0]   i_out_n;
    logic [NFLAG-1:0]  i_set, i_clr;
    logic              x_ac_we, x_e_we, x_skip, x_halt;
    logic [DATA_W-1:0] x_ac_n;

    assign take = (state_q == ST_IDLE) && start;
    assign exec = (state_q == ST_EXEC);

    rio_reg_alu #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_alu (
        .sel(sel_q), .ac(ac_q), .e(e_q),
        .ac_n(r_ac_n), .ac_we(r_ac_we), .e_n(r_e_n), .e_we(r_e_we),
        .skip(r_skip), .halt(r_halt)
    );

    rio_io_ops #(.DATA_W(DATA_W), .IO_W(IO_W), .SEL_W(SEL_W)) u_io (
        .sel(sel_q), .ac_lo(ac_q[IO_W-1:0]), .in_reg(in_q),
        .fgi(flags[FL_IN]), .fgo(flags[FL_OUT]),
        .ac_n(i_ac_n), .ac_we(i_ac_we), .out_n(i_out_n), .out_we(i_out_we),
        .skip(i_skip), .fl_set(i_set), .fl_clr(i_clr)
    );

    // group mux, gated by the execute state
    assign x_ac_n  = ind_q ? i_ac_n : r_ac_n;
    assign x_ac_we = exec && (ind_q ? i_ac_we : r_ac_we);
    assign x_e_we  = exec && !ind_q && r_e_we;
    assign x_skip  = ind_q ? i_skip : r_skip;
    assign x_halt  = !ind_q && r_halt;

    // peripheral sets take priority inside rio_flags
    always_comb begin
        fl_set         = (exec && ind_q) ? i_set : '0;
        fl_set[FL_IN]  = fl_set[FL_IN]  | in_strobe;
        fl_set[FL_OUT] = fl_set[FL_OUT] | out_ack;
        fl_clr         = (exec && ind_q) ? i_clr : '0;
        fl_clr[FL_IN]  = fl_clr[FL_IN]  & ~in_strobe;
        fl_clr[FL_OUT] = fl_clr[FL_OUT] & ~out_ack;
    end

    rio_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_v(fl_set), .clr_v(fl_clr), .q(flags)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EXEC;
            ST_EXEC:   state_d = x_halt ? ST_HALTED : ST_IDLE;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ind_q  <= 1'b0;
            ac_q   <= '0;
            e_q    <= 1'b0;
            in_q   <= '0;
            out_q  <= '0;
            skip_q <= 1'b0;
            done_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (take) begin
                sel_q <= sel;
                ind_q <= ind;
            end
            if (x_ac_we)    ac_q <= x_ac_n;
            else if (ac_wr) ac_q <= ac_wdata;
            if (x_e_we)     e_q  <= r_e_n;
            else if (e_wr)  e_q  <= e_wdata;
            if (exec && ind_q && i_out_we) out_q <= i_out_n;
            if (in_strobe) in_q <= in_data;
            skip_q <= exec && x_skip;
            done_q <= exec;
            if (exec && x_halt) halt_q <= 1'b1;
        end
    end

    assign ac       = ac_q;
    assign e        = e_q;
    assign ien      = flags[FL_IEN];
    assign fgi      = flags[FL_IN];
    assign fgo      = flags[FL_OUT];
    assign out_data = out_q;
    assign skip     = skip_q;
    assign halt     = halt_q;
    assign done     = done_q;

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ##2 done);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
    // R3
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> !done);
    // R4
    skip_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> done);
    // R11
    in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> fgi);
    // R11
    out_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ack |=> fgo);

endmodule

// File: tb/tb_rio_exec_unit.sv
module tb_rio_exec_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] ac;
        logic        e, ien, fgi, fgo;
        logic [7:0]  outd;
        logic        skip, halt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, ind = 1'b0;
    logic [5:0]  sel = '0;
    logic        ac_wr = 1'b0, e_wr = 1'b0, e_wdata = 1'b0;
    logic [15:0] ac_wdata = '0;
    logic        in_strobe = 1'b0, out_ack = 1'b0;
    logic [7:0]  in_data = '0;
    logic [15:0] ac;
    logic        e, ien, fgi, fgo, skip, halt, done;
    logic [7:0]  out_data;

    int checks = 0, fails = 0;
    bit finished = 0;
    exp_t q[$];

    logic [15:0] m_ac;
    logic        m_e, m_ien, m_fgi, m_fgo, m_halt;
    logic [7:0]  m_in, m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    rio_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .ind(ind),
        .ac_wr(ac_wr), .ac_wdata(ac_wdata), .e_wr(e_wr), .e_wdata(e_wdata),
        .in_strobe(in_strobe), .in_data(in_data), .out_ack(out_ack),
        .ac(ac), .e(e), .ien(ien), .fgi(fgi), .fgo(fgo), .out_data(out_data),
        .skip(skip), .halt(halt), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: compare each done pulse with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(0, "R2/R3", "done pulse with nothing expected (act done=1 exp done=0)");
            end else begin
                exp_t x;
                x = q.pop_front();
                check(ac == x.ac && e == x.e && ien == x.ien && fgi == x.fgi &&
                      fgo == x.fgo && out_data == x.outd && skip == x.skip && halt == x.halt,
                      x.tag,
                      $sformatf("act ac=%h e=%b ien=%b fgi=%b fgo=%b out=%h skip=%b halt=%b exp ac=%h e=%b ien=%b fgi=%b fgo=%b out=%h skip=%b halt=%b",
                          ac, e, ien, fgi, fgo, out_data, skip, halt,
                          x.ac, x.e, x.ien, x.fgi, x.fgo, x.outd, x.skip, x.halt));
            end
        end
    end

    task automatic model_reset();
        m_ac = '0; m_e = 0; m_ien = 0; m_fgi = 0; m_fgo = 0; m_halt = 0;
        m_in = '0; m_out = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1 reset state
        check(ac == 0 && e == 0 && ien == 0 && fgi == 0 && fgo == 0 && out_data == 0 &&
              skip == 0 && halt == 0 && done == 0, "R1",
              $sformatf("act ac=%h e=%b flags=%b%b%b out=%h skip=%b halt=%b done=%b exp all 0",
                        ac, e, ien, fgi, fgo, out_data, skip, halt, done));
    endtask

    task automatic load(input logic [15:0] v, input logic ev);
        @(negedge clk);
        ac_wr = 1; ac_wdata = v; e_wr = 1; e_wdata = ev;
        @(negedge clk);
        ac_wr = 0; e_wr = 0;
        m_ac = v; m_e = ev;
    endtask

    task automatic dev_in(input logic [7:0] d);
        @(negedge clk);
        in_strobe = 1; in_data = d;
        @(negedge clk);
        in_strobe = 0;
        m_in = d; m_fgi = 1;
        check(fgi == 1, "R11", $sformatf("fgi act=%b exp=1", fgi));
    endtask

    task automatic dev_out();
        @(negedge clk);
        out_ack = 1;
        @(negedge clk);
        out_ack = 0;
        m_fgo = 1;
        check(fgo == 1, "R11", $sformatf("fgo act=%b exp=1", fgo));
    endtask

    // driver: model the operation, push the expectation, drive the strobe
    task automatic run_op(input logic [5:0] c, input bit i, input string tag,
                          input bit hold = 0, input bit s_in = 0, input logic [7:0] s_data = 0,
                          input bit s_out = 0, input bit s_wr = 0, input logic [15:0] s_wv = 0);
        exp_t x;
        bit sk = 0, acw = 0;
        if (!i) begin
            case (c)
                0: m_halt = 1;
                1: sk = !m_e;
                2: sk = (m_ac == 0);
                3: sk = m_ac[15];
                4: sk = !m_ac[15];
                5: begin m_ac = m_ac + 1; acw = 1; end
                6: begin {m_e, m_ac} = {m_ac, m_e}; acw = 1; end
                7: begin {m_ac, m_e} = {m_e, m_ac}; acw = 1; end
                8: m_e = ~m_e;
                9: begin m_ac = ~m_ac; acw = 1; end
                10: m_e = 0;
                11: begin m_ac = 0; acw = 1; end
                default: ;
            endcase
        end else begin
            case (c)
                1: m_ien = 0;
                2: m_ien = 1;
                4: sk = m_fgo;
                8: sk = m_fgi;
                16: begin m_out = m_ac[7:0]; m_fgo = 0; end
                32: begin m_ac = {8'h00, m_in}; m_fgi = 0; acw = 1; end
                default: ;
            endcase
        end
        if (s_in) begin m_in = s_data; m_fgi = 1; end
        if (s_out) m_fgo = 1;
        if (s_wr && !acw) m_ac = s_wv;
        x.ac = m_ac; x.e = m_e; x.ien = m_ien; x.fgi = m_fgi; x.fgo = m_fgo;
        x.outd = m_out; x.skip = sk; x.halt = m_halt; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
        start = 1; sel = c; ind = i;
        @(negedge clk);
        start = hold;
        in_strobe = s_in; in_data = s_data; out_ack = s_out;
        ac_wr = s_wr; ac_wdata = s_wv;
        @(negedge clk);
        start = 0; in_strobe = 0; out_ack = 0; ac_wr = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        load(16'h8001, 1'b0);
        run_op(1, 0, "R4 skip e zero");
        run_op(3, 0, "R4 skip negative");
        run_op(4, 0, "R4 no skip positive");
        run_op(2, 0, "R4 no skip zero");
        run_op(6, 0, "R6 rotate left");
        run_op(7, 0, "R6 rotate right");
        run_op(8, 0, "R7 complement e");
        run_op(1, 0, "R4 no skip e set");
        run_op(7, 0, "R6 rotate right with e");
        run_op(10, 0, "R7 clear e");
        run_op(9, 0, "R5 complement ac");
        run_op(5, 0, "R5 increment");
        load(16'hFFFF, 1'b1);
        run_op(5, 0, "R5 increment wrap");
        run_op(2, 0, "R4 skip ac zero");
        run_op(9, 0, "R5 complement zero");
        run_op(11, 0, "R5 clear ac");

        run_op(2, 1, "R8 set ien");
        run_op(1, 1, "R8 clear ien");
        run_op(8, 1, "R9 no skip input idle");
        dev_in(8'hA5);
        dev_out();
        run_op(8, 1, "R9 skip input ready");
        run_op(4, 1, "R9 skip output ready");
        load(16'h1234, 1'b0);
        run_op(16, 1, "R10 output byte");
        run_op(4, 1, "R9 no skip after output");
        run_op(32, 1, "R10 input byte");
        run_op(8, 1, "R9 no skip after input");

        load(16'h5A5A, 1'b1);
        run_op(12, 0, "R12 reg code 12");
        run_op(63, 0, "R12 reg code 63");
        run_op(3, 1, "R12 io two bits");
        run_op(0, 1, "R12 io zero");
        run_op(6'h30, 1, "R12 io high bits");

        // collisions: peripheral set against io clear
        dev_in(8'h3C);
        run_op(32, 1, "R11 input strobe during input op", 0, 1, 8'h77);
        run_op(32, 1, "R11 new input byte kept");
        run_op(16, 1, "R11 output ack during output op", 0, 0, 0, 1);

        // collisions: external write against execution
        load(16'h0100, 1'b0);
        run_op(5, 0, "R13 increment beats write", 0, 0, 0, 0, 1, 16'hBEEF);
        run_op(1, 0, "R13 write during skip op", 0, 0, 0, 0, 1, 16'hBEEF);

        run_op(5, 0, "R2 start held through exec", 1);

        run_op(0, 0, "R3 halt");
        @(negedge clk);
        start = 1; sel = 6'd5; ind = 0;
        @(negedge clk);
        start = 0;
        repeat (4) @(negedge clk);
        check(halt == 1 && ac == m_ac, "R3",
              $sformatf("act halt=%b ac=%h exp halt=1 ac=%h", halt, ac, m_ac));
        check(q.size() == 0, "R2",
              $sformatf("pending expectations act=%0d exp=0", q.size()));

        do_reset();
        run_op(5, 0, "R1 runs after reset");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule